// File: doc/BRIEF.md
# Daisy-Chain Serial Result Reader

This block is the host-side collector for a string of identical current-input converters. The devices share one serial data clock, and each device's serial output feeds the serial input of the next device. When the converters signal that results are ready by pulling an active-low ready line, the reader starts toggling the data clock. It shifts in 64 channel words from every device in the chain, most significant bit first. Each word is 20 bits wide, or 16 bits in the reduced-resolution format.

Every word is turned from offset binary into two's complement and left-aligned to the full 20-bit scale. It is then offered on a valid/ready stream together with its channel index, its device index and a flag that marks the final word of the read. A strobe sequencer supplies a quiet-window input that covers every conversion-strobe edge. While that window is open the data clock is held low. Shifting resumes at the same bit once the window closes.

The data clock idles low. It runs at a period of 2×HALF_CYC system cycles. If a new ready edge arrives while a read is still in progress, a one-cycle error pulse is raised.

Top module: `chain_result_reader`

## Requirements
- R1: After reset, dclk, m_valid and err_overrun are all low.
- R2: dclk stays low while no read is in progress. A read starts only when dvalid_n goes from high to low.
- R3: Each high phase of dclk lasts exactly HALF_CYC cycles unless the quiet window cuts it short. Each low phase lasts at least HALF_CYC cycles.
- R4: In the cycle after any cycle with guard high, dclk is low, and no rising edge is produced while guard is high. A pause keeps the bit position, so the words after the pause are still correct.
- R5: sdo is sampled at each rising dclk edge, most significant bit first. With fmt_wide = 1 each word is 20 bits.
- R6: With fmt_wide = 0 each word is 16 bits, placed at m_data[19:4] with m_data[3:0] = 0. fmt_wide is sampled only when a read starts.
- R7: The output is the received word with bit 19 inverted. The raw value 0 gives 0x80000, the raw value all-ones gives 0x7FFFF, and the raw midpoint 0x80000 gives 0.
- R8: A read yields NUM_DEV×CH_PER_DEV words. m_chan counts 0..CH_PER_DEV-1 within each device, and m_dev counts from 0, where 0 is the device nearest the reader. m_last is high only with m_chan = CH_PER_DEV-1 and m_dev = NUM_DEV-1.
- R9: While m_valid is high and m_ready is low, m_valid, m_data, m_chan, m_dev and m_last hold. No word is lost: dclk stalls before the last bit of a word until the output slot is free.
- R10: A falling edge on dvalid_n during a read gives a one-cycle pulse on err_overrun, and the ongoing read continues unchanged.
- R11: After the high phase that carries the last bit ends, the reader returns to idle, and the next falling edge on dvalid_n starts a new read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_wide | input | 1 | 1: 20-bit words, 0: 16-bit words; sampled at read start |
| dvalid_n | input | 1 | Active-low results-ready line from the chain |
| guard | input | 1 | Quiet window around strobe edges; dclk is held low while it is high |
| sdo | input | 1 | Serial data from the last device of the chain |
| dclk | output | 1 | Shared serial data clock, idle low |
| m_valid | output | 1 | Stream word valid |
| m_ready | input | 1 | Stream consumer ready |
| m_data | output | WORD_W (20) | Two's complement word, left-aligned |
| m_chan | output | CHW (6) | Channel index within the device |
| m_dev | output | DEVW (1) | Device index, 0 nearest the reader |
| m_last | output | 1 | Final word of the read |
| err_overrun | output | 1 | One-cycle pulse on a ready edge during a read |

## Verification
A bit counter that slips by one shifts every word after it. The next handshake then shows a wrong m_data that has the wrong MSB polarity or stray low bits, and m_last appears on the wrong index. A miscounted channel or device counter shows up at the latest on the final word, as a missing or displaced m_last. A fault in the clock phase counter or in the quiet-window logic shows in the dclk waveform itself within a single half period: high phases of the wrong length, or dclk high one cycle after guard was high. A sequencing state that does not return to idle, or that starts a read without a ready edge, is seen directly as dclk toggling outside a read.

// File: rtl/crr_pkg.sv
package crr_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } rd_state_e;

    // index width that never collapses to zero bits
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/crr_dclk_gen.sv
module crr_dclk_gen
    import crr_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,     // more bits wanted
    input  logic guard,   // quiet window
    input  logic hold,    // output slot busy, do not start the next rise
    output logic dclk,
    output logic rise     // dclk goes high at the coming edge: sample now
);
    localparam int CW = idx_w(HALF_CYC);
    localparam logic [CW-1:0] PH_LAST = CW'(HALF_CYC - 1);

    typedef struct packed {
        logic          dclk;
        logic [CW-1:0] cnt;
    } gen_s;

    gen_s q, d;

    always_comb begin
        d    = q;
        rise = 1'b0;
        if (guard) begin
            // force low at once; restart a full low phase afterwards
            d.dclk = 1'b0;
            d.cnt  = '0;
        end else if (q.dclk) begin
            if (q.cnt == PH_LAST) begin
                d.dclk = 1'b0;
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if (run) begin
            if (q.cnt == PH_LAST) begin
                if (!hold) begin
                    d.dclk = 1'b1;
                    d.cnt  = '0;
                    rise   = 1'b1;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dclk = q.dclk;

endmodule

// File: rtl/crr_word_asm.sv
module crr_word_asm
    import crr_pkg::*;
#(
    parameter int WORD_W   = 20,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide,
    input  logic              capture,
    input  logic              sdo,
    output logic              last_bit,
    output logic              word_done,
    output logic [WORD_W-1:0] word
);
    localparam int BW    = idx_w(WORD_W);
    localparam int SHIFT = WORD_W - NARROW_W;

    typedef struct packed {
        logic [BW-1:0]     bcnt;
        logic [WORD_W-1:0] sh;
    } asm_s;

    asm_s q, d;

    logic [BW-1:0]     bit_last;
    logic [WORD_W-1:0] full;
    logic [WORD_W-1:0] raw;

    always_comb begin
        bit_last  = wide ? BW'(WORD_W - 1) : BW'(NARROW_W - 1);
        last_bit  = (q.bcnt == bit_last);
        full      = {q.sh[WORD_W-2:0], sdo};
        // narrow words are left-aligned so both formats share one scale
        raw       = wide ? full : (full << SHIFT);
        word      = {~raw[WORD_W-1], raw[WORD_W-2:0]};
        word_done = capture && last_bit;

        d = q;
        if (start) begin
            d.bcnt = '0;
        end else if (capture) begin
            d.sh   = full;
            d.bcnt = last_bit ? '0 : q.bcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/chain_result_reader.sv
module chain_result_reader
    import crr_pkg::*;
#(
    parameter int NUM_DEV    = 2,
    parameter int CH_PER_DEV = 64,
    parameter int WORD_W     = 20,
    parameter int NARROW_W   = 16,
    parameter int HALF_CYC   = 2,
    localparam int CHW       = idx_w(CH_PER_DEV),
    localparam int DEVW      = idx_w(NUM_DEV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_wide,
    input  logic              dvalid_n,
    input  logic              guard,
    input  logic              sdo,
    output logic              dclk,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [WORD_W-1:0] m_data,
    output logic [CHW-1:0]    m_chan,
    output logic [DEVW-1:0]   m_dev,
    output logic              m_last,
    output logic              err_overrun
);
    localparam logic [CHW-1:0]  CH_LAST  = CHW'(CH_PER_DEV - 1);
    localparam logic [DEVW-1:0] DEV_LAST = DEVW'(NUM_DEV - 1);

    typedef struct packed {
        rd_state_e         st;
        logic              dv;
        logic              wide;
        logic              done;
        logic [CHW-1:0]    chan;
        logic [DEVW-1:0]   dev;
        logic              ov;
        logic [WORD_W-1:0] data;
        logic [CHW-1:0]    ochan;
        logic [DEVW-1:0]   odev;
        logic              olast;
        logic              err;
    } rd_s;

    rd_s q, d;

    logic              dv_fall, start_rd, run, hold, rise;
    logic              last_bit, word_done;
    logic [WORD_W-1:0] word;

    crr_dclk_gen #(
        .HALF_CYC (HALF_CYC)
    ) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .guard (guard),
        .hold  (hold),
        .dclk  (dclk),
        .rise  (rise)
    );

    crr_word_asm #(
        .WORD_W   (WORD_W),
        .NARROW_W (NARROW_W)
    ) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_rd),
        .wide      (q.wide),
        .capture   (rise),
        .sdo       (sdo),
        .last_bit  (last_bit),
        .word_done (word_done),
        .word      (word)
    );

    always_comb begin
        dv_fall  = q.dv && !dvalid_n;
        start_rd = dv_fall && (q.st == ST_IDLE);
        run      = (q.st == ST_SHIFT) && !q.done;
        hold     = last_bit && q.ov;

        d     = q;
        d.dv  = dvalid_n;
        d.err = dv_fall && (q.st != ST_IDLE);

        if (q.ov && m_ready) begin
            d.ov = 1'b0;
        end

        if (start_rd) begin
            d.st   = ST_SHIFT;
            d.wide = fmt_wide;
            d.done = 1'b0;
            d.chan = '0;
            d.dev  = '0;
        end

        if (word_done) begin
            d.ov    = 1'b1;
            d.data  = word;
            d.ochan = q.chan;
            d.odev  = q.dev;
            d.olast = (q.chan == CH_LAST) && (q.dev == DEV_LAST);
            if (q.chan == CH_LAST) begin
                d.chan = '0;
                if (q.dev == DEV_LAST) begin
                    d.done = 1'b1;
                end else begin
                    d.dev = q.dev + 1'b1;
                end
            end else begin
                d.chan = q.chan + 1'b1;
            end
        end

        // leave only once the final high phase is over
        if ((q.st == ST_SHIFT) && q.done && !dclk) begin
            d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.dv <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign m_valid     = q.ov;
    assign m_data      = q.data;
    assign m_chan      = q.ochan;
    assign m_dev       = q.odev;
    assign m_last      = q.olast;
    assign err_overrun = q.err;

endmodule

// File: rtl/crr_reader_chk.sv
module crr_reader_chk #(
    parameter int NUM_DEV    = 2,
    parameter int CH_PER_DEV = 64,
    parameter int WORD_W     = 20,
    parameter int HALF_CYC   = 2,
    parameter int CHW        = 6,
    parameter int DEVW       = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              idle,
    input logic              guard,
    input logic              dclk,
    input logic              m_valid,
    input logic              m_ready,
    input logic [WORD_W-1:0] m_data,
    input logic [CHW-1:0]    m_chan,
    input logic [DEVW-1:0]   m_dev,
    input logic              m_last,
    input logic              err_overrun
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (!dclk) begin
            hi_cnt <= '0;
        end else begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !dclk);

    assert_high_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dclk) && !$past(guard)) |-> (hi_cnt == 16'(HALF_CYC)));

    assert_guard_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        guard |=> !dclk);

    assert_last_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_last) |-> ((m_chan == CHW'(CH_PER_DEV - 1)) && (m_dev == DEVW'(NUM_DEV - 1))));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_chan)
                                   && $stable(m_dev) && $stable(m_last)));

    assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |=> !err_overrun);

endmodule

bind chain_result_reader crr_reader_chk #(
    .NUM_DEV    (NUM_DEV),
    .CH_PER_DEV (CH_PER_DEV),
    .WORD_W     (WORD_W),
    .HALF_CYC   (HALF_CYC),
    .CHW        (CHW),
    .DEVW       (DEVW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle        (q.st == ST_IDLE),
    .guard       (guard),
    .dclk        (dclk),
    .m_valid     (m_valid),
    .m_ready     (m_ready),
    .m_data      (m_data),
    .m_chan      (m_chan),
    .m_dev       (m_dev),
    .m_last      (m_last),
    .err_overrun (err_overrun)
);

// File: tb/chain_result_reader_bench.sv
`timescale 1ns/1ps
module chain_result_reader_bench;
    localparam int NDEV  = 2;
    localparam int NCH   = 64;
    localparam int WW    = 20;
    localparam int NW    = 16;
    localparam int HC    = 2;
    localparam int TOTAL = NDEV * NCH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fmt_wide = 1'b1;
    logic dvalid_n = 1'b1;
    logic guard = 1'b0;
    logic m_ready = 1'b1;
    logic sdo;
    logic dclk, m_valid, m_last, err_overrun;
    logic [WW-1:0] m_data;
    logic [5:0] m_chan;
    logic [0:0] m_dev;

    int n_cmp = 0;
    int n_bad = 0;
    int seq_id = 0;
    bit src_wide = 1'b1;
    int bi = 0;
    int out_k = 0;
    int err_seen = 0;
    int exp_err = 0;
    bit seq_open = 1'b0;

    always #2.5 clk = ~clk;

    chain_result_reader #(
        .NUM_DEV(NDEV), .CH_PER_DEV(NCH), .WORD_W(WW), .NARROW_W(NW), .HALF_CYC(HC)
    ) u_chain_result_reader (
        .clk(clk), .rst_n(rst_n), .fmt_wide(fmt_wide), .dvalid_n(dvalid_n),
        .guard(guard), .sdo(sdo), .dclk(dclk), .m_valid(m_valid), .m_ready(m_ready),
        .m_data(m_data), .m_chan(m_chan), .m_dev(m_dev), .m_last(m_last),
        .err_overrun(err_overrun)
    );

    // raw device word k of read s, with corner values at the start
    function automatic logic [31:0] raw_word(input int s, input int k, input bit w);
        int nb;
        logic [31:0] m;
        nb = w ? WW : NW;
        m  = (32'd1 << nb) - 1;
        if (k == 0) return 32'd0;
        if (k == 1) return m;
        if (k == 2) return 32'd1 << (nb - 1);
        return (s * 977 + k * 7919 + k * k * 13 + 5) & m;
    endfunction

    function automatic logic src_bit(input int s, input bit w, input int b);
        int nb, k, pos;
        logic [31:0] r;
        nb = w ? WW : NW;
        k  = b / nb;
        pos = nb - 1 - (b % nb);
        if (k >= TOTAL) return 1'b0;
        r = raw_word(s, k, w);
        return r[pos];
    endfunction

    function automatic logic [WW-1:0] exp_data(input int s, input int k, input bit w);
        logic [31:0] r;
        logic [WW-1:0] v;
        r = raw_word(s, k, w);
        v = w ? r[WW-1:0] : WW'(r[NW-1:0]) << (WW - NW);
        v[WW-1] = ~v[WW-1];
        return v;
    endfunction

    assign sdo = src_bit(seq_id, src_wide, bi);

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    // reference monitor, evaluated every clock at the falling edge
    bit g_prev = 1'b0, d_prev = 1'b0, cut = 1'b0, stall_prev = 1'b0;
    int hi_run = 0, lo_run = 0;
    logic [WW-1:0] data_prev;
    logic [5:0] chan_prev;

    always @(negedge clk) begin
        if (rst_n) begin
            bit cut_now;
            chk(!(g_prev && dclk), "R4", "dclk high after guard", dclk, 0);
            if (!seq_open) chk(!dclk, "R2", "dclk outside read", dclk, 0);
            cut_now = cut | g_prev;
            if (!dclk && d_prev) begin
                if (!cut_now) chk(hi_run == HC, "R3", "high phase length", hi_run, HC);
                hi_run = 0;
                cut = 1'b0;
                lo_run = 1;
            end else if (dclk && !d_prev) begin
                chk(lo_run >= HC, "R3", "low phase length", lo_run, HC);
                hi_run = 1;
                cut = cut_now;
                bi++;
            end else if (dclk) begin
                hi_run++;
                cut = cut_now;
            end else begin
                lo_run++;
            end
            if (stall_prev) begin
                chk(m_valid && m_data == data_prev && m_chan == chan_prev, "R9",
                    "stalled word changed", m_data, data_prev);
            end
            if (m_valid && m_ready) begin
                chk(m_data == exp_data(seq_id, out_k, src_wide),
                    src_wide ? "R7" : "R6", "word data", m_data, exp_data(seq_id, out_k, src_wide));
                chk(m_chan == 6'(out_k % NCH) && m_dev == 1'(out_k / NCH),
                    "R8", "word index", {m_dev, m_chan}, out_k);
                chk(m_last == (out_k == TOTAL - 1), "R8", "last flag", m_last, out_k == TOTAL - 1);
                out_k++;
            end
            if (err_overrun) err_seen++;
            stall_prev = m_valid && !m_ready;
            data_prev  = m_data;
            chan_prev  = m_chan;
            g_prev = guard;
            d_prev = dclk;
        end
    end

    task automatic run_seq(input int s, input bit w);
        @(posedge clk); #2;
        seq_id = s; src_wide = w; bi = 0; out_k = 0;
        fmt_wide = w; seq_open = 1'b1; dvalid_n = 1'b0;
        while (!dclk) @(negedge clk);
        @(posedge clk); #2;
        dvalid_n = 1'b1;
        fmt_wide = ~w;              // R6: must not affect the running read
        while (out_k < TOTAL) @(negedge clk);
        while (dclk) @(negedge clk);
        repeat (4) @(negedge clk);
        seq_open = 1'b0;
        chk(out_k == TOTAL, "R8", "words per read", out_k, TOTAL);
        chk(!m_valid, "R11", "stream idle after read", m_valid, 0);
        chk(err_seen == exp_err, "R10", "overrun pulses", err_seen, exp_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog expired: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (8) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(!dclk && !m_valid && !err_overrun, "R1", "reset outputs",
            {dclk, m_valid, err_overrun}, 0);
        repeat (40) @(negedge clk);     // R2: idle with no ready edge

        // R5 R7 wide format, free-running consumer
        run_seq(1, 1'b1);
        // R6 narrow format
        run_seq(2, 1'b0);
        // R4 pauses cutting words at arbitrary bits
        fork
            run_seq(3, 1'b1);
            begin
                for (int i = 0; i < 24; i++) begin
                    repeat (150 + i * 13) @(posedge clk);
                    #2 guard = 1'b1;
                    repeat (9 + i % 5) @(posedge clk);
                    #2 guard = 1'b0;
                end
            end
        join
        // R9 backpressure, narrow
        fork
            run_seq(4, 1'b0);
            begin
                repeat (5) @(posedge clk);
                while (seq_open) begin
                    @(posedge clk); #2 m_ready = (($urandom % 3) != 0);
                end
                m_ready = 1'b1;
            end
        join
        m_ready = 1'b1;
        // R10 R11 ready edge during a read, then back-to-back read
        fork
            run_seq(5, 1'b1);
            begin
                repeat (3000) @(posedge clk);
                #2 dvalid_n = 1'b0;
                exp_err = 1;
                repeat (5) @(posedge clk);
                #2 dvalid_n = 1'b1;
            end
        join
        run_seq(6, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule